// File: doc/BRIEF.md
# Energy Pulse Output Generator

This block turns two streams of signed per-sample energy increments, one for active and one for reactive energy, into active-low pulses on three output pins. Each channel keeps a signed running total. Every time the magnitude of a total goes beyond a programmable quantum, the channel raises one pulse request and removes one quantum from its total. The remainder carries over to later samples.

A single pulse sequencer serves the requests. For each pulse it:
- drives the direction pin,
- waits a fixed setup time,
- holds the selected pulse pin low for a fixed width,
- rests, so that two pulse falls are never closer than a fixed period.

All of these times are counted in master-clock cycles. Each channel can queue one request while the sequencer is busy. Further requests that arrive while one is already queued are discarded. Because only one pulse is in flight at a time, the active and reactive pulses can never overlap. Small mode selects pick what the second and third pins show.

Top module: `energyPulseGen`

## Requirements
- R1: After reset all three outputs are high, both channel totals are zero and no request is queued.
- R2: On each cycle with `sampleValid` high, each channel adds its signed energy to its total. If the new total is strictly greater than `threshold`, the channel raises a positive request and subtracts `threshold`. If it is strictly less than minus `threshold`, the channel raises a negative request and adds `threshold`. A total exactly equal to ±`threshold` raises no request.
- R3: A channel raises at most one request per sample, and the remainder stays in its total. A later sample, even one of zero energy, can raise a further request from that remainder.
- R4: With the sequencer idle, a request raised at clock edge N makes the selected pulse pin fall at edge N+SETUP_CYC+1.
- R5: Every pulse stays low for exactly WIDTH_CYC cycles.
- R6: With `e2Mode`=0, `e2N` shows the direction of the latest pulse: low means negative, high means positive. It is updated at edge N+1, which is SETUP_CYC cycles before that pulse falls, and it holds until the next pulse's setup begins.
- R7: Active-channel pulses appear on `e1N`. With `e3Mode`=0, reactive-channel pulses appear on `e3N`.
- R8: Any two consecutive pulse falls are at least PERIOD_CYC cycles apart. When requests are queued back to back, they are exactly PERIOD_CYC cycles apart.
- R9: A request that arrives while the sequencer is busy is queued, one deep per channel. A further request on that channel while one is still queued is dropped, but its quantum is still removed from the total.
- R10: When both channels have a request queued, the reactive pulse goes first, unless the previous pulse was reactive, in which case the active pulse goes first. `e1N` and `e3N` are never low together.
- R11: With `e2Mode`=1, `e2N` repeats the reactive pulse, falling and rising on the same edges as the reactive pulse.
- R12: With `e3Mode`=1, `e3N` shows the direction of the latest pulse: low means negative. With `e3Mode`=2 or 3, `e3N` stays high. In every mode, reactive pulses still take their slot in the sequencer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | One energy sample per channel is presented this cycle |
| activeEnergy | input | IN_W | Signed active energy increment |
| reactiveEnergy | input | IN_W | Signed reactive energy increment |
| threshold | input | ACC_W-1 | Unsigned energy quantum per pulse |
| e2Mode | input | 1 | 0: direction on `e2N`; 1: copy of the reactive pulse |
| e3Mode | input | 2 | 0: reactive pulse; 1: direction level; 2/3: held high |
| e1N | output | 1 | Active energy pulse, active low |
| e2N | output | 1 | Direction or reactive pulse copy |
| e3N | output | 1 | Reactive pulse, direction level or idle high |

## Verification
The timing is counted from the clock edge that samples an increment.
- The request is registered at that edge (edge N).
- The sequencer takes the request at edge N+1; the direction level changes there.
- The pulse pin falls at edge N+SETUP_CYC+1 and rises WIDTH_CYC edges after that.
- A queued pulse falls exactly PERIOD_CYC edges after the previous fall.

The bench keeps a free-running edge count and records the edge count of every fall and rise on all three pins, sampling on the falling clock edge. Each directed test then compares the recorded edge numbers with these offsets, worked out from the edge on which the bench presented the sample. Tests that expect no pulse wait longer than a full period before they check that the pin saw no fall.

// File: rtl/energyPulsePkg.sv
`timescale 1ns/1ps
package energyPulsePkg;
  localparam int CH_ACT = 0;
  localparam int CH_REA = 1;

  // control -> datapath
  typedef struct packed {
    logic [1:0] take;   // request of that channel moves into the sequencer
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic [1:0] pend;   // queued request per channel
    logic [1:0] neg;    // direction of the queued request
  } pendStat_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_LOW, ST_REST} seqState_t;
endpackage

// File: rtl/energyAccum.sv
`timescale 1ns/1ps
module energyAccum #(
  parameter int IN_W  = 24,
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleValid,
  input  logic signed [IN_W-1:0]  energy,
  input  logic [ACC_W-2:0]        threshold,
  input  logic                    take,
  output logic                    pend,
  output logic                    neg
);
  logic signed [ACC_W-1:0] acc, sum, thrS, nextAcc;
  logic reqNow, reqNeg;

  always_comb begin
    sum     = acc + {{(ACC_W-IN_W){energy[IN_W-1]}}, energy};
    thrS    = $signed({1'b0, threshold});
    reqNow  = 1'b0;
    reqNeg  = 1'b0;
    nextAcc = sum;
    if (sum > thrS) begin
      reqNow  = 1'b1;
      nextAcc = sum - thrS;
    end else if (sum < -thrS) begin
      reqNow  = 1'b1;
      reqNeg  = 1'b1;
      nextAcc = sum + thrS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc  <= '0;
      pend <= 1'b0;
      neg  <= 1'b0;
    end else begin
      if (sampleValid) acc <= nextAcc;
      if (sampleValid && reqNow && (!pend || take)) begin
        pend <= 1'b1;
        neg  <= reqNeg;
      end else if (take) begin
        pend <= 1'b0;
      end
    end
  end

  // R9: a queued request is neither replaced nor lost by a later one
  a_r9_pend_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pend && !take && sampleValid && reqNow) |=> (pend && $stable(neg)));
endmodule

// File: rtl/energyPulseData.sv
`timescale 1ns/1ps
module energyPulseData
  import energyPulsePkg::*;
#(
  parameter int IN_W  = 24,
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleValid,
  input  logic signed [IN_W-1:0]  activeEnergy,
  input  logic signed [IN_W-1:0]  reactiveEnergy,
  input  logic [ACC_W-2:0]        threshold,
  input  ctlStrobe_t              strobe,
  output pendStat_t               stat
);
  localparam int N_CH = 2;

  logic signed [IN_W-1:0] chanEnergy [N_CH];
  logic [N_CH-1:0] pendV, negV;

  assign chanEnergy[CH_ACT] = activeEnergy;
  assign chanEnergy[CH_REA] = reactiveEnergy;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    energyAccum #(.IN_W(IN_W), .ACC_W(ACC_W)) u_acc (
      .clk         (clk),
      .rstN        (rstN),
      .sampleValid (sampleValid),
      .energy      (chanEnergy[g]),
      .threshold   (threshold),
      .take        (strobe.take[g]),
      .pend        (pendV[g]),
      .neg         (negV[g])
    );
  end

  assign stat.pend = pendV;
  assign stat.neg  = negV;
endmodule

// File: rtl/energyPulseCtrl.sv
`timescale 1ns/1ps
module energyPulseCtrl
  import energyPulsePkg::*;
#(
  parameter int SETUP_CYC  = 25,
  parameter int WIDTH_CYC  = 1000,
  parameter int PERIOD_CYC = 2048
) (
  input  logic       clk,
  input  logic       rstN,
  input  pendStat_t  stat,
  input  logic       e2Mode,
  input  logic [1:0] e3Mode,
  output ctlStrobe_t strobe,
  output logic       e1N,
  output logic       e2N,
  output logic       e3N
);
  localparam int REST_CYC = PERIOD_CYC - SETUP_CYC - WIDTH_CYC - 1;
  localparam int CNT_W    = $clog2(PERIOD_CYC + 1);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] WIDTH_LAST = CNT_W'(WIDTH_CYC - 1);
  localparam logic [CNT_W-1:0] REST_LAST  = CNT_W'(REST_CYC - 1);

  seqState_t state;
  logic [CNT_W-1:0] cnt;
  logic sel3, lastWas3, signNeg, pick3, anyPend, stLow, actLow, reaLow;

  always_comb begin
    anyPend = |stat.pend;
    pick3   = stat.pend[CH_REA] && !(stat.pend[CH_ACT] && lastWas3);
    strobe.take = 2'b00;
    if (state == ST_IDLE && anyPend) strobe.take = pick3 ? 2'b10 : 2'b01;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sel3     <= 1'b0;
      lastWas3 <= 1'b0;
      signNeg  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (anyPend) begin
          state    <= ST_SETUP;
          cnt      <= '0;
          sel3     <= pick3;
          lastWas3 <= pick3;
          signNeg  <= pick3 ? stat.neg[CH_REA] : stat.neg[CH_ACT];
        end
        ST_SETUP: if (cnt == SETUP_LAST) begin
          state <= ST_LOW; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        ST_LOW: if (cnt == WIDTH_LAST) begin
          state <= ST_REST; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: if (cnt == REST_LAST) begin
          state <= ST_IDLE; cnt <= '0;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  assign stLow  = (state == ST_LOW);
  assign actLow = stLow && !sel3;
  assign reaLow = stLow && sel3;
  assign e1N    = !actLow;
  assign e2N    = e2Mode ? !reaLow : !signNeg;
  always_comb begin
    case (e3Mode)
      2'd0:    e3N = !reaLow;
      2'd1:    e3N = !signNeg;
      default: e3N = 1'b1;
    endcase
  end

  // ---- assertion support counters ----
  localparam int AGE_W = $clog2(SETUP_CYC + 1);
  logic [CNT_W-1:0] lowRun, sinceFall;
  logic [AGE_W-1:0] signAge;
  logic stLowQ, seenFall, signQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun <= '0; sinceFall <= '0; seenFall <= 1'b0; stLowQ <= 1'b0;
      signQ <= 1'b0; signAge <= AGE_W'(SETUP_CYC);
    end else begin
      stLowQ <= stLow;
      signQ  <= signNeg;
      lowRun <= stLow ? lowRun + 1'b1 : '0;
      if (stLow && !stLowQ) begin
        sinceFall <= CNT_W'(1); seenFall <= 1'b1;
      end else if (sinceFall != CNT_W'(PERIOD_CYC)) sinceFall <= sinceFall + 1'b1;
      if (signNeg != signQ) signAge <= AGE_W'(1);
      else if (signAge != AGE_W'(SETUP_CYC)) signAge <= signAge + 1'b1;
    end
  end

  // R5: each pulse stays low for exactly the width
  a_r5_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stLow) |-> (lowRun == CNT_W'(WIDTH_CYC)));
  // R8: falls are at least a period apart
  a_r8_period: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(stLow) && seenFall) |-> (sinceFall >= CNT_W'(PERIOD_CYC)));
  // R6: direction is settled for the setup time before any fall
  a_r6_e2_setup: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stLow) |-> (signAge >= AGE_W'(SETUP_CYC)));
  // R10: active and reactive pulse pins never low together
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    (e3Mode == 2'd0) |-> (e1N || e3N));
endmodule

// File: rtl/energyPulseGen.sv
`timescale 1ns/1ps
module energyPulseGen
  import energyPulsePkg::*;
#(
  parameter int IN_W       = 24,
  parameter int ACC_W      = 32,
  parameter int SETUP_CYC  = 25,
  parameter int WIDTH_CYC  = 1000,
  parameter int PERIOD_CYC = 2048
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sampleValid,
  input  logic signed [IN_W-1:0] activeEnergy,
  input  logic signed [IN_W-1:0] reactiveEnergy,
  input  logic [ACC_W-2:0]       threshold,
  input  logic                   e2Mode,
  input  logic [1:0]             e3Mode,
  output logic                   e1N,
  output logic                   e2N,
  output logic                   e3N
);
  ctlStrobe_t strobe;
  pendStat_t  stat;

  energyPulseData #(.IN_W(IN_W), .ACC_W(ACC_W)) u_data (
    .clk            (clk),
    .rstN           (rstN),
    .sampleValid    (sampleValid),
    .activeEnergy   (activeEnergy),
    .reactiveEnergy (reactiveEnergy),
    .threshold      (threshold),
    .strobe         (strobe),
    .stat           (stat)
  );

  energyPulseCtrl #(.SETUP_CYC(SETUP_CYC), .WIDTH_CYC(WIDTH_CYC),
                    .PERIOD_CYC(PERIOD_CYC)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .stat   (stat),
    .e2Mode (e2Mode),
    .e3Mode (e3Mode),
    .strobe (strobe),
    .e1N    (e1N),
    .e2N    (e2N),
    .e3N    (e3N)
  );
endmodule

// File: tb/energyPulseGen_bench.sv
`timescale 1ns/1ps
module energyPulseGen_bench;
  localparam int IN_W = 24, ACC_W = 32;
  localparam int SETUP = 25, WIDTH = 1000, PERIOD = 2048;

  logic clk = 1'b0, rstN = 1'b0, sampleValid = 1'b0, e2Mode = 1'b0;
  logic [1:0] e3Mode = 2'd0;
  logic signed [IN_W-1:0] activeEnergy = '0, reactiveEnergy = '0;
  logic [ACC_W-2:0] threshold = 31'd100;
  logic e1N, e2N, e3N;

  energyPulseGen #(.IN_W(IN_W), .ACC_W(ACC_W), .SETUP_CYC(SETUP),
                   .WIDTH_CYC(WIDTH), .PERIOD_CYC(PERIOD)) u_energyPulseGen (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .activeEnergy(activeEnergy), .reactiveEnergy(reactiveEnergy),
    .threshold(threshold), .e2Mode(e2Mode), .e3Mode(e3Mode),
    .e1N(e1N), .e2N(e2N), .e3N(e3N));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 0;
  int fCnt [3], fT [3], fFirst [3], rT [3];
  logic prevP [3];
  bit overlapSeen;

  task automatic clearMon();
    for (int i = 0; i < 3; i++) begin
      fCnt[i] = 0; fT[i] = -1; fFirst[i] = -1; rT[i] = -1; prevP[i] = 1'b1;
    end
    overlapSeen = 0;
  endtask

  always @(negedge clk) begin
    logic [2:0] pins;
    pins = {e3N, e2N, e1N};
    for (int i = 0; i < 3; i++) begin
      if (prevP[i] && !pins[i]) begin
        fCnt[i]++; fT[i] = cyc;
        if (fFirst[i] < 0) fFirst[i] = cyc;
      end
      if (!prevP[i] && pins[i]) rT[i] = cyc;
      prevP[i] = pins[i];
    end
    if (!e1N && !e3N && e3Mode == 2'd0) overlapSeen = 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; sampleValid = 1'b0; activeEnergy = '0; reactiveEnergy = '0;
    e2Mode = 1'b0; e3Mode = 2'd0; threshold = 31'd100;
    waitCyc(3);
    clearMon();
    rstN = 1'b1;
    waitCyc(2);
  endtask

  // presents one sample; returns the edge count that samples it
  task automatic send(input int a, input int r, output int s);
    activeEnergy = IN_W'(a); reactiveEnergy = IN_W'(r);
    sampleValid = 1'b1;
    s = cyc + 1;
    @(negedge clk);
    sampleValid = 1'b0; activeEnergy = '0; reactiveEnergy = '0;
  endtask

  task automatic testReset();
    int s;
    doReset();
    chk(e1N === 1'b1, "R1 e1N after reset", int'(e1N), 1);
    chk(e2N === 1'b1, "R1 e2N after reset", int'(e2N), 1);
    chk(e3N === 1'b1, "R1 e3N after reset", int'(e3N), 1);
    send(60, 0, s);                 // total 60: no pulse if started at zero
    waitCyc(SETUP + 50);
    chk(fCnt[0] == 0, "R1 total starts at zero", fCnt[0], 0);
    send(50, 0, s);                 // 110 > 100
    waitCyc(SETUP + 10);
    chk(fT[0] == s + SETUP + 1, "R1 pulse after second sample", fT[0], s + SETUP + 1);
  endtask

  task automatic testActivePos();
    int s;
    doReset();
    send(150, 0, s);
    waitCyc(SETUP + WIDTH + 20);
    chk(fT[0] == s + SETUP + 1, "R4 fall edge", fT[0], s + SETUP + 1);
    chk(rT[0] - fT[0] == WIDTH, "R5 width", rT[0] - fT[0], WIDTH);
    chk(fCnt[2] == 0, "R7 no E3 for active", fCnt[2], 0);
    chk(fCnt[1] == 0 && e2N, "R6 E2 high for positive", fCnt[1], 0);
  endtask

  task automatic testThreshold();
    int s;
    doReset();
    send(150, 0, s);                // 150 -> pulse, 50 left
    send(50, 0, s);                 // 100 == threshold: no request
    waitCyc(PERIOD + 100);
    chk(fCnt[0] == 1, "R2 equal to threshold gives no pulse", fCnt[0], 1);
    send(1, 0, s);                  // 101 -> pulse
    waitCyc(SETUP + 10);
    chk(fT[0] == s + SETUP + 1, "R2 just above threshold", fT[0], s + SETUP + 1);
    doReset();
    send(350, 0, s);                // one request only, 250 left
    waitCyc(PERIOD + 100);
    chk(fCnt[0] == 1, "R3 one request per sample", fCnt[0], 1);
    send(0, 0, s);                  // remainder 250 -> request
    waitCyc(SETUP + 10);
    chk(fT[0] == s + SETUP + 1, "R3 remainder kept", fT[0], s + SETUP + 1);
  endtask

  task automatic testReactiveNeg();
    int s;
    doReset();
    send(0, -150, s);
    waitCyc(SETUP + WIDTH + 20);
    chk(fT[2] == s + SETUP + 1, "R7 reactive pulse on E3", fT[2], s + SETUP + 1);
    chk(fT[1] == s + 1, "R6 E2 falls at setup start", fT[1], s + 1);
    chk(fT[2] - fT[1] == SETUP, "R6 E2 setup ahead of fall", fT[2] - fT[1], SETUP);
    chk(e2N === 1'b0, "R6 E2 held low after pulse", int'(e2N), 0);
    chk(fCnt[0] == 0, "R7 no E1 for reactive", fCnt[0], 0);
    chk(rT[2] - fT[2] == WIDTH, "R5 reactive width", rT[2] - fT[2], WIDTH);
  endtask

  task automatic testPending();
    int s0, s1, s2;
    doReset();
    send(150, 0, s0);
    send(150, 0, s1);               // queued
    send(150, 0, s2);               // dropped
    waitCyc(3 * PERIOD + 100);
    chk(fFirst[0] == s0 + SETUP + 1, "R4 first fall", fFirst[0], s0 + SETUP + 1);
    chk(fT[0] - fFirst[0] == PERIOD, "R8 back-to-back spacing", fT[0] - fFirst[0], PERIOD);
    chk(fCnt[0] == 2, "R9 one-deep queue", fCnt[0], 2);
  endtask

  task automatic testBoth();
    int s, sLate;
    doReset();
    send(150, 150, s);
    waitCyc(200);
    send(0, 150, sLate);            // 50 + 150 -> second reactive request
    waitCyc(3 * PERIOD);
    chk(fFirst[2] == s + SETUP + 1, "R10 reactive served first", fFirst[2], s + SETUP + 1);
    chk(fT[0] == s + SETUP + 1 + PERIOD, "R10 active next after reactive", fT[0], s + SETUP + 1 + PERIOD);
    chk(fT[2] == s + SETUP + 1 + 2 * PERIOD, "R10 reactive again third", fT[2], s + SETUP + 1 + 2 * PERIOD);
    chk(fCnt[2] == 2 && fCnt[0] == 1, "R10 pulse counts", fCnt[2] * 10 + fCnt[0], 21);
    chk(!overlapSeen, "R10 no overlap", int'(overlapSeen), 0);
  endtask

  task automatic testE2Mode();
    int s;
    doReset();
    e2Mode = 1'b1;
    send(0, 150, s);
    waitCyc(SETUP + WIDTH + 20);
    chk(fCnt[1] == 1 && fT[1] == fT[2], "R11 E2 falls with reactive", fT[1], fT[2]);
    chk(rT[1] == rT[2], "R11 E2 rises with reactive", rT[1], rT[2]);
  endtask

  task automatic testE3Modes();
    int s;
    doReset();
    e3Mode = 2'd1;
    send(-150, 0, s);
    waitCyc(SETUP + WIDTH + 20);
    chk(fT[2] == s + 1, "R12 E3 direction level falls", fT[2], s + 1);
    chk(e3N === 1'b0, "R12 E3 held low for negative", int'(e3N), 0);
    chk(fT[0] == s + SETUP + 1, "R12 E1 pulse in mode 1", fT[0], s + SETUP + 1);
    doReset();
    e3Mode = 2'd2;
    send(150, 150, s);
    waitCyc(2 * PERIOD);
    chk(fCnt[2] == 0, "R12 E3 idle in mode 2", fCnt[2], 0);
    chk(fT[0] == s + SETUP + 1 + PERIOD, "R12 hidden reactive slot", fT[0], s + SETUP + 1 + PERIOD);
  endtask

  initial begin
    clearMon();
    testReset();
    testActivePos();
    testThreshold();
    testReactiveNeg();
    testPending();
    testBoth();
    testE2Mode();
    testE3Modes();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule